// File: doc/BRIEF.md
# Two-Wire Segment Data Target with Readback

This block is the bus-target side of a multiplexed display driver's data path. It watches a two-wire bus: a clock line driven by a controller and an open-drain data line. It recognises start and stop conditions. After a start it takes in an address byte. The upper seven bits of that byte select this device, and the lowest bit chooses between writing and reading. When the address matches, the block acknowledges by pulling the data line low for the ninth clock of the byte.

In a write, every data byte is acknowledged in the same way. The bits fill a shift register one display frame wide, 128 bits by default. That register is copied into the display latch in one of two ways:
- automatically, each time a full frame of bits has arrived, while the enable input is high;
- when the enable input rises during a clock-high interval, if enable is held low.

In a read, the block returns the shift register first-in first-out, MSB first. It releases the data line on every ninth clock so the controller can acknowledge. The register recirculates while it is read, and the display latch is left untouched.

Top module: `seg_bus_target`

## Requirements
- R1: A falling data line while the clock is high is a start. It restarts address reception from any state and clears the frame bit count. A rising data line while the clock is high is a stop. It returns the block to idle with the data line released.
- R2: The address byte is received MSB first. Its upper seven bits must equal 0111111 (parameter ADDR) for the block to respond. Bit 0 equal to 0 selects a write and 1 selects a read. On a mismatch, the block drives nothing until the next start.
- R3: After a matching address, and after each written data byte, the block pulls the data line low from the clock fall that follows the eighth rise until the clock fall that follows the ninth rise. It does not drive the line during the eight data clocks of a written byte.
- R4: Write data is shifted into the frame register MSB first, one bit per rising clock. The first bit of the frame ends up in the register MSB.
- R5: With enable high, the register is copied to the display latch on the rising clock that delivers the last bit of a frame.
- R6: With enable low, a full frame does not change the display latch. A rising edge of enable while the clock is high copies the register into the latch.
- R7: After the acknowledge clock of a completed frame, the next rising clock is ignored, whatever the data line holds. Reception then continues with the following rising clock as the first bit of a new frame.
- R8: In a read, the block drives the register out MSB first, first-in first-out, and changes the data line only while the clock is low. It releases the line on each ninth clock. A high level on the line at that ninth rise ends the read. After a whole frame has been read, the register holds its original contents, and the display latch is never changed during a read.
- R9: After reset, the display latch is all zeros and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Bus clock from the controller |
| sda | input | 1 | Resolved level of the bus data line |
| en | input | 1 | Latch enable: high for automatic latching, a rising pulse for manual latching |
| sda_oe | output | 1 | When high, the target pulls the data line low |
| disp | output | N | Display latch contents, frame bit 0 at the MSB |

## Verification
Frames are written with random byte patterns in both latch modes. Each frame is then read back, which confirms MSB-first order and first-in first-out order and catches any bit or byte misalignment. A directed frame run with the channel held open sends a zero on the skipped clock. That separates a design that ignores the edge from one that shifts the zero in and shifts the frame by one bit. Separate directed cases cover:
- a wrong address, which must get no acknowledge and leave the latch unchanged;
- a repeated start in the middle of a byte, which must realign reception;
- a second read of the same frame, which shows that recirculation keeps the register contents intact.

// File: rtl/seg_bus_target.sv
module seg_bus_target #(
  parameter int N = 128,
  parameter logic [6:0] ADDR = 7'b0111111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scl,
  input  logic         sda,
  input  logic         en,
  output logic         sda_oe,
  output logic [N-1:0] disp
);
  localparam int TW = $clog2(N);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_SKIP, S_RD, S_RGAP
  } st_t;

  st_t st;
  logic scl_q, sda_q, en_q, half, rd, wrap;
  logic [2:0] bcnt;
  logic [6:0] abyte;
  logic [TW-1:0] total;
  logic [N-1:0] sreg;

  wire rise    = scl & ~scl_q;
  wire fall    = ~scl & scl_q;
  wire start   = scl & scl_q & sda_q & ~sda;
  wire stop    = scl & scl_q & ~sda_q & sda;
  wire reading = (st == S_RD) || (st == S_RGAP);
  wire [N-1:0] shin = {sreg[N-2:0], sda};
  wire [N-1:0] rot  = {sreg[N-2:0], sreg[N-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      en_q <= 1'b0;
      half <= 1'b0;
      rd <= 1'b0;
      wrap <= 1'b0;
      bcnt <= '0;
      abyte <= '0;
      total <= '0;
      sreg <= '0;
      disp <= '0;
      sda_oe <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      en_q <= en;
      if (en && !en_q && scl && !reading) disp <= sreg;
      if (start) begin
        st <= S_ADDR;
        bcnt <= '0;
        total <= '0;
        half <= 1'b0;
        wrap <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE;
        half <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR: if (rise) begin
            abyte <= {abyte[5:0], sda};
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              if (abyte == ADDR) begin
                st <= S_AACK;
                rd <= sda;
              end else st <= S_IDLE;
            end
          end
          S_AACK: if (fall) begin
            if (!half) begin
              sda_oe <= 1'b1;
              half <= 1'b1;
            end else begin
              half <= 1'b0;
              if (rd) begin
                st <= S_RD;
                sda_oe <= ~sreg[N-1];
              end else begin
                st <= S_WR;
                sda_oe <= 1'b0;
              end
            end
          end
          S_WR: if (rise) begin
            sreg <= shin;
            bcnt <= bcnt + 3'd1;
            if (total == TW'(N-1)) begin
              total <= '0;
              wrap <= 1'b1;
              if (en) disp <= shin;
            end else total <= total + 1'b1;
            if (bcnt == 3'd7) st <= S_WACK;
          end
          S_WACK: if (fall) begin
            if (!half) begin
              sda_oe <= 1'b1;
              half <= 1'b1;
            end else begin
              half <= 1'b0;
              sda_oe <= 1'b0;
              wrap <= 1'b0;
              st <= wrap ? S_SKIP : S_WR;
            end
          end
          S_SKIP: if (rise) st <= S_WR;
          S_RD: begin
            if (rise) begin
              sreg <= rot;
              bcnt <= bcnt + 3'd1;
              if (bcnt == 3'd7) st <= S_RGAP;
            end else if (fall) sda_oe <= ~sreg[N-1];
          end
          S_RGAP: begin
            if (fall) begin
              if (!half) begin
                sda_oe <= 1'b0;
                half <= 1'b1;
              end else begin
                half <= 1'b0;
                st <= S_RD;
                sda_oe <= ~sreg[N-1];
              end
            end else if (rise && half && sda) begin
              st <= S_IDLE;
              half <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r8_oe_moves_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl));

  a_r3_drive_only_ack_or_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> (st == S_AACK || st == S_WACK || st == S_RD));

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  a_r8_read_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_RD || $past(st) == S_RGAP) |-> $stable(disp));

  a_r4_byte_aligned_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WACK || st == S_RGAP || st == S_AACK) |-> (bcnt == 3'd0));

endmodule

// File: tb/sim_seg_bus_target.sv
module sim_seg_bus_target;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, en = 1'b1;
  wire sda_oe;
  wire [127:0] disp;
  wire sda_line = sda_m & ~sda_oe;
  int nvec = 0, nbad = 0;

  seg_bus_target u0 (.clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_line),
                     .en(en), .sda_oe(sda_oe), .disp(disp));

  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd_frame();
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic bus_start;
    sda_m = 1'b1; tick(4); scl = 1'b1; tick(4); sda_m = 1'b0; tick(4); scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(4); scl = 1'b1; tick(4); sda_m = 1'b1; tick(4);
  endtask

  task automatic clk_bit(input logic b, output logic smp, output logic oe_s);
    sda_m = b; tick(4); scl = 1'b1; tick(2);
    smp = sda_line; oe_s = sda_oe;
    tick(2); scl = 1'b0; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack_ok, output logic quiet);
    logic s, o;
    quiet = 1'b1;
    for (int i = 0; i < 8; i++) begin
      clk_bit(v[7-i], s, o);
      if (o) quiet = 1'b0;
    end
    clk_bit(1'b1, s, o);
    ack_ok = ~s;
  endtask

  task automatic get_byte(input logic last, output logic [7:0] v, output logic rel);
    logic s, o;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s, o);
      v[7-i] = s;
    end
    clk_bit(last, s, o);
    rel = ~o;
  endtask

  task automatic write_frame(input logic [127:0] d, output int bad);
    logic a, q;
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      send_byte(d[127-8*i -: 8], a, q);
      if (!a || !q) bad++;
    end
  endtask

  task automatic read_frame(output logic [127:0] d, output int bad);
    logic r;
    logic [7:0] b;
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      get_byte(i == 15, b, r);
      d[127-8*i -: 8] = b;
      if (!r) bad++;
    end
  endtask

  task automatic en_pulse;
    en = 1'b1; tick(4); en = 1'b0; tick(4);
  endtask

  initial begin
    logic [127:0] fa, fb, fc, got;
    logic a, q;
    int bad;
    void'($urandom(32'h5eed_c0de));
    tick(3);
    chk("R9 reset latch", disp, '0);
    chk("R9 reset oe", {127'd0, sda_oe}, '0);
    rst_n = 1'b1; tick(4);

    // R2 R3 R4 R5: auto-latch write
    fa = rnd_frame();
    en = 1'b1;
    bus_start; send_byte(8'h7E, a, q);
    chk("R3 address ack", {127'd0, a}, 128'd1);
    write_frame(fa, bad);
    chk("R3 R4 data acks", 128'(bad), '0);
    bus_stop;
    chk("R5 auto latch", disp, fa);

    // R2 mismatched address
    bus_start; send_byte(8'h7C, a, q);
    chk("R2 no ack on mismatch", {127'd0, a}, '0);
    send_byte(8'h00, a, q);
    chk("R2 silent after mismatch", {127'd0, a}, '0);
    bus_stop;
    chk("R2 latch unchanged", disp, fa);

    // R6 manual latch
    fb = rnd_frame();
    en = 1'b0;
    bus_start; send_byte(8'h7E, a, q); write_frame(fb, bad); bus_stop;
    chk("R6 acks", 128'(bad), '0);
    chk("R6 no auto latch", disp, fa);
    en_pulse;
    chk("R6 pulse latch", disp, fb);

    // R8 read back twice
    bus_start; send_byte(8'h7F, a, q);
    chk("R8 read address ack", {127'd0, a}, 128'd1);
    read_frame(got, bad); bus_stop;
    chk("R8 fifo readback", got, fb);
    chk("R8 release on ninth", 128'(bad), '0);
    chk("R8 latch unchanged by read", disp, fb);
    bus_start; send_byte(8'h7F, a, q); read_frame(got, bad); bus_stop;
    chk("R8 contents preserved", got, fb);

    // R7 open channel with skipped edge carrying a zero
    fa = rnd_frame(); fb = rnd_frame(); fb[127] = 1'b1;
    en = 1'b1;
    bus_start; send_byte(8'h7E, a, q); write_frame(fa, bad);
    chk("R7 first frame", disp, fa);
    clk_bit(1'b0, a, q);
    write_frame(fb, bad);
    chk("R7 acks second frame", 128'(bad), '0);
    bus_stop;
    chk("R7 second frame aligned", disp, fb);

    // R1 repeated start mid-byte
    fc = rnd_frame();
    bus_start; send_byte(8'h7E, a, q);
    for (int i = 0; i < 3; i++) send_byte(8'hA5, a, q);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, a, q);
    bus_start; send_byte(8'h7E, a, q);
    chk("R1 restart ack", {127'd0, a}, 128'd1);
    write_frame(fc, bad); bus_stop;
    chk("R1 realigned after restart", disp, fc);
    chk("R1 released after stop", {127'd0, sda_oe}, '0);

    // random rounds
    for (int k = 0; k < 6; k++) begin
      logic mode;
      fa = rnd_frame();
      mode = 1'($urandom);
      en = mode;
      bus_start; send_byte(8'h7E, a, q); write_frame(fa, bad); bus_stop;
      chk("R4 random acks", 128'(bad), '0);
      if (!mode) begin
        chk("R6 random hold", disp, fc);
        en_pulse;
      end
      chk(mode ? "R5 random latch" : "R6 random latch", disp, fa);
      bus_start; send_byte(8'h7F, a, q); read_frame(got, bad); bus_stop;
      chk("R8 random readback", got, fa);
      fc = fa;
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nvec++; nbad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule